// File: doc/BRIEF.md
# BCD-Programmed Frequency Divider

This block divides its clock by a modulus N between 1 and 3999. N is supplied as a binary-coded decimal word, one group of bits per decimal digit, as a bank of rotary decimal switches would deliver it. Four decade counter stages count clock edges in decimal. A one-cycle terminal pulse marks the end of each group of N edges. A second output stays high for the first half of each cycle, so a phase comparator that needs a wide input pulse can use it.

A small state machine controls the counter. State `ST_LOAD` is entered at reset and waits for a legal word. Transition LOAD→LOAD is taken while the word is illegal. Transition LOAD→RUN is taken on the first edge that sees a legal word; that edge captures the word and sets the count to 1. State `ST_RUN` counts. Its only transition is RUN→RUN. At the terminal count the counter restarts at 1, and the word is captured again if it is legal. An illegal word is flagged and leaves the modulus in use unchanged.

Top module: `bcd_divider`

## Requirements
- R1: While reset (`rst_ni` low) is asserted, `term_o`, `half_o` and `bad_o` are all 0.
- R2: The program word holds the thousands digit in bits [13:12] (values 0–3), hundreds in [11:8], tens in [7:4] and units in [3:0]. The modulus is its decimal value; for example 896 is 00_1000_1001_0110 and 1079 is 01_0000_0111_1001.
- R3: In the running state, `term_o` is high for exactly one clock out of every N consecutive clocks, for every N from 1 to 3999. For N = 1 it is high on every clock.
- R4: In each N-clock cycle, `half_o` is high for the first floor(N/2) clocks after the terminal clock and low for the rest. For N = 1 it is never high.
- R5: A word is illegal if any of the hundreds, tens or units digits exceeds 9, or if the word is zero. `bad_o` reports, one clock later, whether the word present at the previous rising edge was illegal.
- R6: When the word is illegal at a terminal count, the modulus already in use is kept and the period does not change.
- R7: A new legal word is captured only on the edge that ends a terminal clock. A change in the middle of a cycle does not shorten or lengthen that cycle, and it sets the period of the following cycle.
- R8: After reset, while the word stays illegal, the block remains in `ST_LOAD` and both `term_o` and `half_o` stay low.
- R9: `term_o` and `half_o` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock whose edges are divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_i | input | 14 | BCD modulus word (thousands in 13:12, then hundreds, tens, units) |
| term_o | output | 1 | One-clock pulse at the terminal count |
| half_o | output | 1 | High for the first half of each count cycle |
| bad_o | output | 1 | Registered flag: the previous word was illegal |

## Verification
The properties assume that `prog_i` is driven from a synchronous source: it changes between clock edges and is never sampled while it is moving. The bench follows this by changing the word only on falling edges. The properties also assume that the thousands field cannot exceed 3, which its two-bit width guarantees. Illegal words are applied as single, deliberate values: a digit code of 10 to 15, or an all-zero word. Each illegal word is held across at least one terminal count, so the property that the modulus is retained is actually exercised.

// File: rtl/bcd_divider_pkg.sv
package bcd_divider_pkg;
    localparam int DIGW = 4;
    localparam logic [DIGW-1:0] DIG_MAX = 4'd9;

    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/bcd_word_check.sv
module bcd_word_check
    import bcd_divider_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic [NDIG*DIGW-1:0] word_i,
    output logic                 ok_o
);
    logic [NDIG-1:0] dig_ok;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        assign dig_ok[g] = (word_i[g*DIGW +: DIGW] <= DIG_MAX);
    end

    assign ok_o = (&dig_ok) && (|word_i);
endmodule

// File: rtl/bcd_halve.sv
module bcd_halve
    import bcd_divider_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic [NDIG*DIGW-1:0] word_i,
    output logic [NDIG*DIGW-1:0] half_o
);
    // Each digit is halved; an odd digit above it contributes 5.
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        logic [DIGW-1:0] base;
        logic            odd_up;
        assign base = word_i[g*DIGW +: DIGW] >> 1;
        if (g == NDIG - 1) begin : g_top
            assign odd_up = 1'b0;
        end else begin : g_mid
            assign odd_up = word_i[(g+1)*DIGW];
        end
        assign half_o[g*DIGW +: DIGW] = base + (odd_up ? DIGW'(5) : DIGW'(0));
    end
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
    import bcd_divider_pkg::*;
#(
    parameter logic [DIGW-1:0] START = '0
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            restart_i,
    input  logic            inc_i,
    output logic [DIGW-1:0] digit_o,
    output logic            carry_o
);
    logic [DIGW-1:0] digit_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            digit_q <= '0;
        end else if (restart_i) begin
            digit_q <= START;
        end else if (inc_i) begin
            digit_q <= (digit_q == DIG_MAX) ? '0 : digit_q + 1'b1;
        end
    end

    assign digit_o = digit_q;
    assign carry_o = inc_i && (digit_q == DIG_MAX);
endmodule

// File: rtl/bcd_divider.sv
module bcd_divider
    import bcd_divider_pkg::*;
#(
    parameter int NDIG     = 4,
    parameter int TOP_BITS = 2
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic [TOP_BITS+DIGW*(NDIG-1)-1:0]     prog_i,
    output logic                                  term_o,
    output logic                                  half_o,
    output logic                                  bad_o
);
    localparam int PW = TOP_BITS + DIGW * (NDIG - 1);
    localparam int CW = DIGW * NDIG;

    div_state_e     state_q, state_d;
    logic [CW-1:0]  prog_ext;
    logic [CW-1:0]  half_w;
    logic           word_ok;
    logic [CW-1:0]  mod_q;
    logic [CW-1:0]  half_q;
    logic [CW-1:0]  cnt_w;
    logic [NDIG:0]  inc_chain;
    logic           run_w;
    logic           at_term;
    logic           restart;
    logic           load_en;
    logic           bad_q;

    assign prog_ext = CW'(prog_i);

    bcd_word_check #(.NDIG(NDIG)) u_check (
        .word_i (prog_ext),
        .ok_o   (word_ok)
    );

    bcd_halve #(.NDIG(NDIG)) u_halve (
        .word_i (prog_ext),
        .half_o (half_w)
    );

    assign run_w   = (state_q == ST_RUN);
    assign at_term = (cnt_w == mod_q);

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_LOAD;
        else         state_q <= state_d;
    end

    // Next state and control
    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        load_en = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                if (word_ok) begin
                    state_d = ST_RUN;
                    restart = 1'b1;
                    load_en = 1'b1;
                end
            end
            ST_RUN: begin
                if (at_term) begin
                    restart = 1'b1;
                    load_en = word_ok;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mod_q  <= '0;
            half_q <= '0;
        end else if (load_en) begin
            mod_q  <= prog_ext;
            half_q <= half_w;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bad_q <= 1'b0;
        else         bad_q <= !word_ok;
    end

    // Cascaded decade counter
    assign inc_chain[0] = run_w && !at_term;

    for (genvar g = 0; g < NDIG; g++) begin : g_stage
        bcd_decade #(.START((g == 0) ? DIGW'(1) : DIGW'(0))) u_dec (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .restart_i (restart),
            .inc_i     (inc_chain[g]),
            .digit_o   (cnt_w[g*DIGW +: DIGW]),
            .carry_o   (inc_chain[g+1])
        );
    end

    // Outputs
    always_comb begin
        term_o = 1'b0;
        half_o = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                term_o = 1'b0;
                half_o = 1'b0;
            end
            ST_RUN: begin
                term_o = at_term;
                half_o = (cnt_w <= half_q);
            end
        endcase
    end

    assign bad_o = bad_q;
endmodule

// File: rtl/bcd_divider_chk.sv
module bcd_divider_chk
    import bcd_divider_pkg::*;
#(
    parameter int NDIG = 4,
    parameter int PW   = 14
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [PW-1:0]        prog_i,
    input logic                 term_o,
    input logic                 half_o,
    input logic                 bad_o,
    input logic                 run_w,
    input logic [NDIG*DIGW-1:0] cnt_w,
    input logic [NDIG*DIGW-1:0] mod_q
);
    localparam int CW = NDIG * DIGW;
    logic [CW-1:0] ext;
    logic          bad_ref;

    always_comb begin
        ext     = CW'(prog_i);
        bad_ref = (ext == '0);
        for (int g = 0; g < NDIG; g++) begin
            if (ext[g*DIGW +: DIGW] > 4'd9) bad_ref = 1'b1;
        end
    end

    // R9
    no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(term_o && half_o));

    // R5
    bad_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bad_ref |=> bad_o);

    // R5
    bad_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bad_ref |=> !bad_o);

    // R3
    term_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term_o |=> (cnt_w == CW'(1)));

    // R7
    hold_mod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_w && !term_o) |=> $stable(mod_q));

    // R8
    load_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_w |-> (!term_o && !half_o));

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        // R3
        digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cnt_w[g*DIGW +: DIGW] <= 4'd9);
    end
endmodule

bind bcd_divider bcd_divider_chk #(.NDIG(NDIG), .PW(PW)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .prog_i (prog_i),
    .term_o (term_o),
    .half_o (half_o),
    .bad_o  (bad_o),
    .run_w  (run_w),
    .cnt_w  (cnt_w),
    .mod_q  (mod_q)
);

// File: tb/bcd_divider_bench.sv
`timescale 1ns/1ps
module bcd_divider_bench;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [13:0] prog_i = 14'b00_0000_0000_1011;
    logic        term_o, half_o, bad_o;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk_i = ~clk_i;

    bcd_divider u_bcd_divider (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .prog_i (prog_i),
        .term_o (term_o),
        .half_o (half_o),
        .bad_o  (bad_o)
    );

    localparam int NV = 10;
    // R2: words written field by field (thousands, hundreds, tens, units)
    localparam logic [13:0] VEC_WORD [NV] = '{
        14'b00_0000_0000_0001,
        14'b00_1000_1001_0110,
        14'b01_0000_0111_1001,
        14'b11_1001_1001_1001,
        14'b00_0000_0001_0000,
        14'b00_0000_0000_0010,
        14'b00_0000_0000_0011,
        14'b00_1001_1001_1001,
        14'b01_0000_0000_0000,
        14'b00_0000_0000_0111
    };
    localparam int VEC_N [NV] = '{1, 896, 1079, 3999, 10, 2, 3, 999, 1000, 7};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_term();
        int guard = 0;
        @(negedge clk_i);
        while (!term_o && guard < 5000) begin
            @(negedge clk_i);
            guard++;
        end
    endtask

    // Counts clocks from one terminal clock to the next and the half_o high clocks.
    task automatic measure(output int per, output int hi, output int both);
        per = 0; hi = 0; both = 0;
        do begin
            @(negedge clk_i);
            per++;
            if (half_o) hi++;
            if (half_o && term_o) both++;
        end while (!term_o && per < 5000);
    endtask

    initial begin
        #600000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int per, hi, both, k, quiet;
        // R1: reset values
        @(negedge clk_i);
        check(term_o == 0, "R1 term_o in reset", term_o, 0);
        check(half_o == 0, "R1 half_o in reset", half_o, 0);
        check(bad_o == 0, "R1 bad_o in reset", bad_o, 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R5: illegal units digit 11 flagged
        check(bad_o == 1, "R5 bad_o for units=11", bad_o, 1);
        // R8: stays idle with an illegal word
        quiet = 0;
        repeat (40) begin
            @(negedge clk_i);
            if (term_o || half_o) quiet++;
        end
        check(quiet == 0, "R8 no output while word illegal", quiet, 0);
        prog_i = VEC_WORD[4];
        @(negedge clk_i);
        check(bad_o == 0, "R5 bad_o clears on legal word", bad_o, 0);

        // Table walk: R2 R3 R4 R9
        for (int i = 0; i < NV; i++) begin
            prog_i = VEC_WORD[i];
            wait_term();
            measure(per, hi, both);
            check(per == VEC_N[i], "R3 period", per, VEC_N[i]);
            check(hi == VEC_N[i] / 2, "R4 half_o high clocks", hi, VEC_N[i] / 2);
            check(both == 0, "R9 term_o and half_o overlap", both, 0);
        end

        // R6: illegal tens digit keeps modulus 10
        prog_i = 14'b00_0000_0001_0000;
        wait_term();
        prog_i = 14'b00_0000_1100_0101;
        @(negedge clk_i);
        check(bad_o == 1, "R5 bad_o for tens=12", bad_o, 1);
        wait_term();
        measure(per, hi, both);
        check(per == 10, "R6 period kept on illegal digit", per, 10);
        prog_i = 14'b00_0000_0000_0000;
        @(negedge clk_i);
        check(bad_o == 1, "R5 bad_o for zero word", bad_o, 1);
        wait_term();
        measure(per, hi, both);
        check(per == 10, "R6 period kept on zero word", per, 10);

        // R7: mid-cycle change does not alter current cycle
        prog_i = 14'b00_0000_0010_0000;
        wait_term();
        measure(per, hi, both);
        check(per == 20, "R7 setup period", per, 20);
        k = 0;
        repeat (5) begin
            @(negedge clk_i);
            k++;
        end
        prog_i = 14'b00_0000_0101_0000;
        while (!term_o && k < 5000) begin
            @(negedge clk_i);
            k++;
        end
        check(k == 20, "R7 current cycle unchanged", k, 20);
        measure(per, hi, both);
        check(per == 50, "R7 new period next cycle", per, 50);
        check(hi == 25, "R4 half_o for 50", hi, 25);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule